// File: doc/BRIEF.md
# PDM Microphone Clock and Capture

This block drives the bit clock for external pulse-density-modulated microphones and gathers their one-bit output from two data pins. Each pin serves one stereo pair of channels. Pin 0 feeds channels 0 and 1, and pin 1 feeds channels 2 and 3. The block runs from a 24 MHz reference. It divides that reference by 16, 12 or 8 to produce a 1.5, 2.0 or 3.0 MHz microphone clock. Once per microphone-clock period it presents a four-bit sample word with a one-cycle valid strobe, and a downstream decimation filter consumes that word.

Each pin can run in one of two modes. In multiplex mode two microphones share the pin and drive it on opposite clock phases. The left bit is taken as the clock rises and the right bit as it falls. In uniplex mode only one microphone drives the pin. Its bit is either copied to both channels (mono) or placed on the left channel only (stereo). Static control inputs set the rate, the mode of each pin, a left/right swap, a mute per channel and a power-down.

Top module: `pdm_mic_if`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `mic_clk`, `smp_valid` and `smp_bits` are all 0. On the first edge after reset the clock starts a new period, rising first.
- R2: With `rate_sel` = 0, each `mic_clk` period is 16 reference cycles: 10 high, then 6 low.
- R3: With `rate_sel` = 1 the period is 12 cycles (6 high, 6 low). With `rate_sel` = 2 or 3 it is 8 cycles (4 high, 4 low).
- R4: `rate_sel` is sampled only when one period ends. Every high phase and every low phase therefore has the length that belongs to a single rate, and no runt pulse appears.
- R5: On a pin in multiplex mode (`pair_mux[p]` = 1), the left bit is the pin value at the reference edge where `mic_clk` rises. The right bit is the pin value at the edge where `mic_clk` falls. On that falling edge, `smp_valid` goes high for one cycle and `smp_bits` is updated.
- R6: On a pin in uniplex mono mode (`pair_mux[p]` = 0, `pair_stereo[p]` = 0), both channels of the pair carry the bit sampled at the rising edge.
- R7: On a pin in uniplex stereo mode (`pair_mux[p]` = 0, `pair_stereo[p]` = 1), the left channel carries the rising-edge bit and the right channel is 0.
- R8: When `swap_lr` = 1, the left and right results of every pair are exchanged after mode processing.
- R9: Channel k sits at `smp_bits[k]`: bit 2p is the left channel of pair p and bit 2p+1 is its right channel. If `mute[k]` = 1 at the falling edge, that bit is 0. Mute is applied after the swap.
- R10: While `power_down` = 1 (from the cycle after it is seen), `mic_clk`, `smp_valid` and `smp_bits` are held at 0. After release, the first edge starts a new period at the rate then on `rate_sel`.
- R11: There is exactly one `smp_valid` pulse per `mic_clk` period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| power_down | input | 1 | Stops the clock and the capture |
| rate_sel | input | 2 | Rate code: 0 is 1.5 MHz, 1 is 2.0 MHz, 2 or 3 is 3.0 MHz |
| pair_mux | input | 2 | Per pin: 1 selects multiplex mode |
| pair_stereo | input | 2 | Per pin, in uniplex mode: 1 selects stereo, 0 selects mono |
| swap_lr | input | 1 | Exchanges left and right in every pair |
| mute | input | 4 | Per-channel mute |
| dm_data | input | 2 | Microphone data pins |
| mic_clk | output | 1 | Microphone clock |
| smp_valid | output | 1 | One-cycle strobe once per period |
| smp_bits | output | 4 | Sample word, one bit per channel |

## Verification
Two events can land in the same reference cycle. The first is a rate change that arrives on the last count of a period, exactly at a boundary. The second is power-down asserted on the very edge where the falling-edge capture and the valid strobe would fire. The bench changes `rate_sel` and pulses `power_down` at random offsets while the data pins toggle randomly every cycle. A behavioural reference model, compared on every clock, then judges which rate governs the next period and whether the strobe is suppressed. Directed measurements of the high and low widths, and a count of strobes over a fixed window, confirm the timing figures.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic [1:0] {
    RATE_SLOW     = 2'd0,
    RATE_MID      = 2'd1,
    RATE_FAST     = 2'd2,
    RATE_FAST_ALT = 2'd3
  } rate_e;

  typedef struct packed {
    logic       mux;
    logic       stereo;
    logic       swap;
    logic [1:0] mute;
  } lane_cfg_t;
endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen #(
  parameter int SLOW_DIV  = 16,
  parameter int SLOW_HIGH = 10,
  parameter int MID_DIV   = 12,
  parameter int FAST_DIV  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate_sel,
  output logic       mic_clk,
  output logic       rise_evt,
  output logic       fall_evt
);
  import pdm_pkg::*;

  localparam int CW = $clog2(SLOW_DIV);
  localparam logic [CW-1:0] S_LAST = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] M_LAST = CW'(MID_DIV - 1);
  localparam logic [CW-1:0] F_LAST = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] S_HIGH = CW'(SLOW_HIGH);
  localparam logic [CW-1:0] M_HIGH = CW'(MID_DIV / 2);
  localparam logic [CW-1:0] F_HIGH = CW'(FAST_DIV / 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;
  logic [CW-1:0] high_len;
  rate_e         rate_q;

  always_comb begin
    case (rate_q)
      RATE_SLOW: begin last_cnt = S_LAST; high_len = S_HIGH; end
      RATE_MID:  begin last_cnt = M_LAST; high_len = M_HIGH; end
      default:   begin last_cnt = F_LAST; high_len = F_HIGH; end
    endcase
  end

  assign rise_evt = run && (cnt == '0);
  assign fall_evt = run && (cnt == high_len);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt     <= '0;
      rate_q  <= rate_e'(rate_sel);
      mic_clk <= 1'b0;
    end else begin
      mic_clk <= (cnt < high_len);
      if (cnt == last_cnt) begin
        cnt    <= '0;
        rate_q <= rate_e'(rate_sel);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdm_lane.sv
module pdm_lane (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                rise_evt,
  input  logic                fall_evt,
  input  logic                din,
  input  pdm_pkg::lane_cfg_t  cfg,
  output logic [1:0]          bits
);
  logic       l_cap;
  logic       r_raw;
  logic [1:0] ordered;

  always_comb begin
    if (cfg.mux)         r_raw = din;
    else if (cfg.stereo) r_raw = 1'b0;
    else                 r_raw = l_cap;
    ordered = cfg.swap ? {l_cap, r_raw} : {r_raw, l_cap};
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      l_cap <= 1'b0;
      bits  <= '0;
    end else begin
      if (rise_evt) l_cap <= din;
      if (fall_evt) bits  <= ordered & ~cfg.mute;
    end
  end
endmodule

// File: rtl/pdm_mic_if.sv
module pdm_mic_if #(
  parameter int NUM_PINS  = 2,
  parameter int SLOW_DIV  = 16,
  parameter int SLOW_HIGH = 10,
  parameter int MID_DIV   = 12,
  parameter int FAST_DIV  = 8,
  localparam int NCH = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                power_down,
  input  logic [1:0]          rate_sel,
  input  logic [NUM_PINS-1:0] pair_mux,
  input  logic [NUM_PINS-1:0] pair_stereo,
  input  logic                swap_lr,
  input  logic [NCH-1:0]      mute,
  input  logic [NUM_PINS-1:0] dm_data,
  output logic                mic_clk,
  output logic                smp_valid,
  output logic [NCH-1:0]      smp_bits
);
  import pdm_pkg::*;

  logic run;
  logic rise_evt;
  logic fall_evt;

  assign run = !power_down;

  pdm_clkgen #(
    .SLOW_DIV (SLOW_DIV),
    .SLOW_HIGH(SLOW_HIGH),
    .MID_DIV  (MID_DIV),
    .FAST_DIV (FAST_DIV)
  ) u_clkgen (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .rate_sel(rate_sel),
    .mic_clk (mic_clk),
    .rise_evt(rise_evt),
    .fall_evt(fall_evt)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
    lane_cfg_t cfg;
    assign cfg.mux    = pair_mux[p];
    assign cfg.stereo = pair_stereo[p];
    assign cfg.swap   = swap_lr;
    assign cfg.mute   = mute[2*p +: 2];

    pdm_lane u_lane (
      .clk     (clk),
      .rst     (rst),
      .run     (run),
      .rise_evt(rise_evt),
      .fall_evt(fall_evt),
      .din     (dm_data[p]),
      .cfg     (cfg),
      .bits    (smp_bits[2*p +: 2])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !run) smp_valid <= 1'b0;
    else             smp_valid <= fall_evt;
  end
endmodule

// File: rtl/pdm_mic_if_chk.sv
module pdm_mic_if_chk #(
  parameter int NUM_PINS  = 2,
  parameter int SLOW_DIV  = 16,
  parameter int SLOW_HIGH = 10,
  parameter int MID_DIV   = 12,
  parameter int FAST_DIV  = 8,
  localparam int NCH = 2 * NUM_PINS
) (
  input logic                clk,
  input logic                rst,
  input logic                power_down,
  input logic [NUM_PINS-1:0] pair_mux,
  input logic [NUM_PINS-1:0] pair_stereo,
  input logic                swap_lr,
  input logic [NCH-1:0]      mute,
  input logic                mic_clk,
  input logic                smp_valid,
  input logic [NCH-1:0]      smp_bits
);
  int hi_len;

  always_ff @(posedge clk) begin
    if (rst)          hi_len <= 0;
    else if (mic_clk) hi_len <= hi_len + 1;
    else              hi_len <= 0;
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid); // R11

  AST_VALID_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $fell(mic_clk)); // R5

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    power_down |=> (!mic_clk && !smp_valid && smp_bits == '0)); // R10

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> (($past(mute) & smp_bits) == '0)); // R9

  AST_STEREO_RIGHT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !$past(pair_mux[0]) && $past(pair_stereo[0]) && !$past(swap_lr))
      |-> !smp_bits[1]); // R7

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
    ($fell(mic_clk) && !$past(power_down) && !$past(rst))
      |-> (hi_len == SLOW_HIGH || hi_len == MID_DIV / 2 || hi_len == FAST_DIV / 2)); // R4
endmodule

bind pdm_mic_if pdm_mic_if_chk #(
  .NUM_PINS (NUM_PINS),
  .SLOW_DIV (SLOW_DIV),
  .SLOW_HIGH(SLOW_HIGH),
  .MID_DIV  (MID_DIV),
  .FAST_DIV (FAST_DIV)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .power_down (power_down),
  .pair_mux   (pair_mux),
  .pair_stereo(pair_stereo),
  .swap_lr    (swap_lr),
  .mute       (mute),
  .mic_clk    (mic_clk),
  .smp_valid  (smp_valid),
  .smp_bits   (smp_bits)
);

// File: tb/pdm_mic_if_bench.sv
module pdm_mic_if_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       power_down = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic [1:0] pair_mux = 2'b11;
  logic [1:0] pair_stereo = 2'b00;
  logic       swap_lr = 1'b0;
  logic [3:0] mute = 4'b0;
  logic [1:0] dm_data = 2'b00;
  logic       mic_clk;
  logic       smp_valid;
  logic [3:0] smp_bits;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdm_mic_if u_pdm_mic_if (
    .clk(clk), .rst(rst), .power_down(power_down), .rate_sel(rate_sel),
    .pair_mux(pair_mux), .pair_stereo(pair_stereo), .swap_lr(swap_lr),
    .mute(mute), .dm_data(dm_data), .mic_clk(mic_clk),
    .smp_valid(smp_valid), .smp_bits(smp_bits)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int per_of(input int r);
    return (r == 0) ? 16 : (r == 1) ? 12 : 8;
  endfunction
  function automatic int hi_of(input int r);
    return (r == 0) ? 10 : (r == 1) ? 6 : 4;
  endfunction

  // behavioural reference model
  int m_cnt = 0, m_rate = 0;
  bit m_clk = 0, m_valid = 0;
  bit [3:0] m_bits = 0;
  bit [1:0] m_left = 0;

  always @(posedge clk) begin
    if (rst || power_down) begin
      m_cnt = 0; m_rate = int'(rate_sel); m_clk = 0; m_valid = 0; m_bits = 0; m_left = 0;
    end else begin
      m_valid = 0;
      if (m_cnt == 0) m_left = dm_data;
      if (m_cnt == hi_of(m_rate)) begin
        m_valid = 1;
        for (int p = 0; p < 2; p++) begin
          bit l, r;
          l = m_left[p];
          r = pair_mux[p] ? dm_data[p] : (pair_stereo[p] ? 1'b0 : m_left[p]);
          if (swap_lr) begin bit t; t = l; l = r; r = t; end
          m_bits[2*p]   = l & ~mute[2*p];
          m_bits[2*p+1] = r & ~mute[2*p+1];
        end
      end
      m_clk = (m_cnt < hi_of(m_rate));
      if (m_cnt == per_of(m_rate) - 1) begin m_cnt = 0; m_rate = int'(rate_sel); end
      else m_cnt++;
    end
  end

  always @(negedge clk) if (!done) begin
    chk(mic_clk === m_clk, "R2/R3/R4 mic_clk", int'(mic_clk), int'(m_clk));
    chk(smp_valid === m_valid, "R5/R11 smp_valid", int'(smp_valid), int'(m_valid));
    chk(smp_bits === m_bits, "R5/R6/R7/R8/R9 smp_bits", int'(smp_bits), int'(m_bits));
  end

  // width measurement at the port
  int run_len = 0, last_hi = 0, last_lo = 0;
  bit prev_clk = 0;
  always @(negedge clk) begin
    if (rst) begin run_len = 0; prev_clk = 0; end
    else if (mic_clk === prev_clk) run_len++;
    else begin
      if (prev_clk) last_hi = run_len; else last_lo = run_len;
      run_len = 1; prev_clk = mic_clk;
    end
  end

  int valid_cnt = 0;
  always @(negedge clk) if (smp_valid === 1'b1) valid_cnt++;

  initial begin
    forever begin @(negedge clk); dm_data = 2'($urandom); end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(mic_clk === 1'b0 && smp_valid === 1'b0 && smp_bits === 4'b0,
        "R1 reset state", int'({mic_clk, smp_valid, smp_bits}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mic_clk === 1'b1, "R1 first rise after reset", int'(mic_clk), 1);

    // R2 / R3: widths per rate code
    for (int r = 0; r < 4; r++) begin
      @(negedge clk); rate_sel = 2'(r);
      repeat (120) @(negedge clk);
      chk(last_hi == hi_of(r), (r == 0) ? "R2 high width" : "R3 high width", last_hi, hi_of(r));
      chk(last_lo == per_of(r) - hi_of(r), (r == 0) ? "R2 low width" : "R3 low width",
          last_lo, per_of(r) - hi_of(r));
    end

    // R11: strobe count over ten slow periods
    rate_sel = 2'd0;
    repeat (64) @(negedge clk);
    valid_cnt = 0;
    repeat (160) @(negedge clk);
    chk(valid_cnt == 10, "R11 strobes per ten periods", valid_cnt, 10);

    // R5..R9: every mode combination, random mutes and rates
    for (int c = 0; c < 32; c++) begin
      pair_mux    = 2'(c);
      pair_stereo = 2'(c >> 2);
      swap_lr     = c[4];
      mute        = 4'($urandom);
      rate_sel    = 2'($urandom);
      repeat (60) @(negedge clk);
    end
    mute = 4'b0;

    // R4: rate changes at arbitrary offsets, including period boundaries
    for (int i = 0; i < 60; i++) begin
      rate_sel = 2'($urandom);
      repeat (1 + ($urandom % 20)) @(negedge clk);
    end

    // R10: power-down bursts at arbitrary offsets
    for (int i = 0; i < 30; i++) begin
      repeat (1 + ($urandom % 25)) @(negedge clk);
      power_down = 1'b1;
      rate_sel = 2'($urandom);
      repeat (1 + ($urandom % 20)) @(negedge clk);
      chk(mic_clk === 1'b0 && smp_valid === 1'b0 && smp_bits === 4'b0,
          "R10 quiet while powered down", int'({mic_clk, smp_valid, smp_bits}), 0);
      power_down = 1'b0;
      @(negedge clk);
      chk(mic_clk === 1'b1, "R10 restart rises first", int'(mic_clk), 1);
    end

    repeat (40) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule